// File: doc/BRIEF.md
# Two-Stage Compare Watchdog

This block is a watchdog that takes no time base of its own. It compares a free-running 64-bit system count, supplied from outside, against a 64-bit deadline register. When the deadline passes for the first time, the block raises a warning output. It then moves the deadline forward by a 32-bit period. If software does not service the watchdog before that second deadline, a reset-request output is raised and stays high.

Software normally programs the period and enables the block. It then services the watchdog by writing any value to a service register, which sits in a separate address region. A first deadline longer than the 32-bit period can reach is set by writing the two 32-bit halves of the deadline register directly. The second stage always uses the period.

A control/status word shows the enable bit and both stage flags. Software can read it after a restart to see whether the watchdog ran out.

Top module: `cmpwd_top`

## Requirements
- R1: After reset the block is disabled, the warning and reset-request outputs are low, and the period register and both halves of the deadline register read 0.
- R2: A write to the period register (main region, byte address 0x08) stores the value and sets the deadline to the sampled system count plus the zero-extended new period, modulo 2^64. The period reads back at 0x08.
- R3: The deadline low half (0x10, bits 31:0) and high half (0x14, bits 63:32) can each be written and read on their own. A directly written deadline beyond 2^32 counts away is honoured by the first stage.
- R4: While enabled in the idle stage, a clock edge at which the system count is at or above the deadline raises the warning output. The same edge reloads the deadline as count plus period.
- R5: While the warning is up, a second such expiry raises the reset request and leaves the warning up. In the reset-request stage, further expiries change neither the outputs nor the deadline.
- R6: A write of any data to word 0x00 of the service region (bus_sel_kick = 1) clears both outputs and reloads the deadline as count plus period. Service-region writes to any other address have no effect.
- R7: While the enable bit is 0, both outputs stay low and no expiry is taken. Writing enable from 0 to 1 reloads the deadline as count plus period. Writing 1 while already enabled does not reload it. Writing 0 clears both stages.
- R8: The control/status word at 0x00 holds enable in bit 0, warning in bit 1 and reset request in bit 2. All other bits read 0, and bits 1 and 2 ignore writes.
- R9: In a cycle that carries any register or service write, no expiry is taken, and the write alone decides the next deadline.
- R10: Reads of unmapped main-region addresses (0x04, 0x0C, 0x18, 0x1C), and all service-region reads, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sys_cnt | input | 64 | Free-running system count value |
| bus_sel_kick | input | 1 | 1 selects the service region, 0 the main register region |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address within the selected region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| warn_o | output | 1 | First-stage warning |
| rstreq_o | output | 1 | Second-stage reset request |

## Verification
The hardest cases to reach are a deadline sum that wraps past 2^64 and a second stage whose reload lands near the top of the count range. A real counter would need years to get there. The bench therefore drives the system count directly as a stimulus value. It steps the count to one below each expected deadline and then onto it, over a sweep of base counts near zero, near a 32-bit carry and near the 64-bit top, crossed with periods of 0, 1, 7 and all-ones. Expiries that collide with bus writes are set up by moving the count past the deadline in the same cycle as the write.

// File: rtl/cmpwd_pkg.sv
`timescale 1ns/1ps
package cmpwd_pkg;
  // main-region byte addresses
  localparam int unsigned ADR_CTRL = 32'h00;
  localparam int unsigned ADR_PER  = 32'h08;
  localparam int unsigned ADR_DLO  = 32'h10;
  localparam int unsigned ADR_DHI  = 32'h14;
  // service-region byte address
  localparam int unsigned ADR_KICK = 32'h00;

  // control/status bit positions
  localparam int unsigned CS_EN   = 0;
  localparam int unsigned CS_WARN = 1;
  localparam int unsigned CS_RST  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WARN  = 2'd1,
    ST_RESET = 2'd2
  } stage_t;

  typedef struct packed {
    logic ctrl;
    logic per;
    logic dlo;
    logic dhi;
    logic kick;
  } wstb_t;
endpackage

// File: rtl/cmpwd_rst_sync.sv
`timescale 1ns/1ps
module cmpwd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmpwd_regif.sv
`timescale 1ns/1ps
module cmpwd_regif
  import cmpwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_kick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              en_q,
  input  logic              warn,
  input  logic              rst_req,
  input  logic [DATA_W-1:0] per_q,
  input  logic [CNT_W-1:0]  dl_q,
  output wstb_t             wstb,
  output logic [DATA_W-1:0] bus_rdata
);
  logic main_wr;
  logic kick_wr;
  logic hit_ctrl, hit_per, hit_dlo, hit_dhi, hit_kick;

  assign hit_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
  assign hit_per  = (bus_addr == ADDR_W'(ADR_PER));
  assign hit_dlo  = (bus_addr == ADDR_W'(ADR_DLO));
  assign hit_dhi  = (bus_addr == ADDR_W'(ADR_DHI));
  assign hit_kick = (bus_addr == ADDR_W'(ADR_KICK));

  assign main_wr = bus_wr & ~bus_sel_kick;
  assign kick_wr = bus_wr &  bus_sel_kick;

  always_comb begin
    wstb.ctrl = main_wr & hit_ctrl;
    wstb.per  = main_wr & hit_per;
    wstb.dlo  = main_wr & hit_dlo;
    wstb.dhi  = main_wr & hit_dhi;
    wstb.kick = kick_wr & hit_kick;
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_sel_kick) begin
      if (hit_ctrl) begin
        bus_rdata[CS_EN]   = en_q;
        bus_rdata[CS_WARN] = warn;
        bus_rdata[CS_RST]  = rst_req;
      end else if (hit_per) begin
        bus_rdata = per_q;
      end else if (hit_dlo) begin
        bus_rdata = dl_q[DATA_W-1:0];
      end else if (hit_dhi) begin
        bus_rdata = dl_q[CNT_W-1:DATA_W];
      end
    end
  end

  // R9: at most one register is written per cycle
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb));

  // R10: the service region never returns data
  p_kick_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel_kick |-> (bus_rdata == '0));
endmodule

// File: rtl/cmpwd_cmp.sv
`timescale 1ns/1ps
module cmpwd_cmp
  import cmpwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  wstb_t             wstb,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reload,
  output logic [DATA_W-1:0] per_q,
  output logic [CNT_W-1:0]  dl_q,
  output logic              expire
);
  logic [DATA_W-1:0] per_d;
  logic              per_en;
  logic [CNT_W-1:0]  dl_d;
  logic              dl_en;
  logic [CNT_W-1:0]  dl_sum;
  logic              load_sum;

  // period next state: a write takes effect in the same cycle's reload sum
  always_comb begin
    per_en = wstb.per;
    per_d  = per_q;
    if (per_en) per_d = wdata;
  end

  assign dl_sum   = sys_cnt + CNT_W'(per_d);
  assign load_sum = wstb.per | wstb.kick | reload;

  always_comb begin
    dl_en = load_sum | wstb.dlo | wstb.dhi;
    dl_d  = dl_q;
    if (load_sum) begin
      dl_d = dl_sum;
    end else begin
      if (wstb.dlo) dl_d[DATA_W-1:0]     = wdata;
      if (wstb.dhi) dl_d[CNT_W-1:DATA_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      per_q <= '0;
    else if (per_en) per_q <= per_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_q <= '0;
    else if (dl_en) dl_q <= dl_d;
  end

  assign expire = (sys_cnt >= dl_q);

  // R2: period write places the deadline one period past the sampled count
  p_per_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.per |=> (dl_q == $past(sys_cnt) + CNT_W'($past(wdata))));

  // R3: a high-half write lands only in the upper word
  p_dhi_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.dhi |=> (dl_q[CNT_W-1:DATA_W] == $past(wdata)) &&
                 (dl_q[DATA_W-1:0] == $past(dl_q[DATA_W-1:0])));

  // R6: service reload uses the unchanged period
  p_kick_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.kick |=> (dl_q == $past(sys_cnt) + CNT_W'(per_q)) && $stable(per_q));
endmodule

// File: rtl/cmpwd_stage.sv
`timescale 1ns/1ps
module cmpwd_stage
  import cmpwd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  wstb_t wstb,
  input  logic  wr_en_bit,
  input  logic  expire,
  output logic  en_q,
  output logic  warn,
  output logic  rst_req,
  output logic  reload
);
  stage_t state_q, state_d;
  logic   en_d;
  logic   en_rise;
  logic   bus_busy;
  logic   take;
  logic   clear;

  assign bus_busy = |wstb;
  assign en_d     = wstb.ctrl ? wr_en_bit : en_q;
  assign en_rise  = wstb.ctrl & wr_en_bit & ~en_q;
  assign clear    = wstb.kick | (wstb.ctrl & ~wr_en_bit);
  assign take     = en_q & expire & ~bus_busy;

  always_comb begin
    state_d = state_q;
    if (clear) begin
      state_d = ST_IDLE;
    end else if (take) begin
      unique case (state_q)
        ST_IDLE:  state_d = ST_WARN;
        ST_WARN:  state_d = ST_RESET;
        ST_RESET: state_d = ST_RESET;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  assign reload = en_rise | (take & (state_q == ST_IDLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (wstb.ctrl) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign warn    = (state_q != ST_IDLE);
  assign rst_req = (state_q == ST_RESET);

  // R7: a disabled watchdog sits in the idle stage
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !warn && !rst_req);

  // R6: a service write clears both stages
  p_kick_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wstb.kick |=> !warn && !rst_req);

  // R5: reset request only follows a warning and then holds
  p_rst_after_warn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(warn));
  p_rst_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !wstb.kick && !wstb.ctrl |=> rst_req);

  // R9: a register write in the idle stage never raises the warning
  p_busy_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy && !warn |=> !warn);
endmodule

// File: rtl/cmpwd_top.sv
`timescale 1ns/1ps
module cmpwd_top
  import cmpwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  sys_cnt,
  input  logic              bus_sel_kick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              warn_o,
  output logic              rstreq_o
);
  logic              srst_n;
  wstb_t             wstb;
  logic              en_q;
  logic              warn;
  logic              rst_req;
  logic              reload;
  logic              expire;
  logic [DATA_W-1:0] per_q;
  logic [CNT_W-1:0]  dl_q;

  cmpwd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cmpwd_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk          (clk),
    .rst_n        (srst_n),
    .bus_sel_kick (bus_sel_kick),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .en_q         (en_q),
    .warn         (warn),
    .rst_req      (rst_req),
    .per_q        (per_q),
    .dl_q         (dl_q),
    .wstb         (wstb),
    .bus_rdata    (bus_rdata)
  );

  cmpwd_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk     (clk),
    .rst_n   (srst_n),
    .sys_cnt (sys_cnt),
    .wstb    (wstb),
    .wdata   (bus_wdata),
    .reload  (reload),
    .per_q   (per_q),
    .dl_q    (dl_q),
    .expire  (expire)
  );

  cmpwd_stage u_stage (
    .clk       (clk),
    .rst_n     (srst_n),
    .wstb      (wstb),
    .wr_en_bit (bus_wdata[CS_EN]),
    .expire    (expire),
    .en_q      (en_q),
    .warn      (warn),
    .rst_req   (rst_req),
    .reload    (reload)
  );

  assign warn_o   = warn;
  assign rstreq_o = rst_req;

  // R4: the warning rises only from an enabled, expired, quiet cycle
  p_warn_cause_r4: assert property (@(posedge srst_n ? clk : 1'b0) disable iff (!srst_n)
    $rose(warn_o) |-> $past(en_q) && $past(expire) && !$past(|wstb));
endmodule

// File: tb/cmpwd_top_tb.sv
`timescale 1ns/1ps
module cmpwd_top_tb;
  logic        clk;
  logic        rst_n;
  logic [63:0] cnt;
  logic        sel;
  logic        wr;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        warn;
  logic        rstreq;

  int n_chk;
  int n_bad;
  logic [63:0] exp_dl;

  cmpwd_top u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_cnt      (cnt),
    .bus_sel_kick (sel),
    .bus_wr       (wr),
    .bus_addr     (addr),
    .bus_wdata    (wdata),
    .bus_rdata    (rdata),
    .warn_o       (warn),
    .rstreq_o     (rstreq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic s, input logic [4:0] a, input logic [31:0] d);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0; sel = 1'b0;
  endtask

  task automatic bus_read(input logic s, input logic [4:0] a, output logic [31:0] d);
    sel = s; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic read_dl(input string tag, output logic [63:0] v);
    logic [31:0] h0, lo, h1;
    bus_read(1'b0, 5'h14, h0);
    bus_read(1'b0, 5'h10, lo);
    bus_read(1'b0, 5'h14, h1);
    check({tag, " hi stable"}, {32'd0, h1}, {32'd0, h0});
    v = {h1, lo};
  endtask

  task automatic check_dl(input string tag, input logic [63:0] exp);
    logic [63:0] v;
    read_dl(tag, v);
    check(tag, v, exp);
  endtask

  task automatic check_out(input string tag, input logic w, input logic r);
    check({tag, " warn"}, {63'd0, warn}, {63'd0, w});
    check({tag, " rstreq"}, {63'd0, rstreq}, {63'd0, r});
  endtask

  // step the count to one below the deadline (if ahead), then onto it
  task automatic run_to_expiry(input string tag, input logic w0, input logic r0);
    if (exp_dl > cnt) begin
      cnt = exp_dl - 64'd1;
      step();
      check_out({tag, " before"}, w0, r0);
      cnt = exp_dl;
    end
    step();
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] bases [4];
    logic [31:0] pers [4];
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; cnt = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    exp_dl = '0;
    bases[0] = 64'd0;
    bases[1] = 64'd1000;
    bases[2] = 64'hFFFF_FFFF_FFFF_FFF8;
    bases[3] = 64'h0000_0002_FFFF_FFFC;
    pers[0] = 32'd0;
    pers[1] = 32'd1;
    pers[2] = 32'd7;
    pers[3] = 32'hFFFF_FFFF;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    bus_read(1'b0, 5'h00, rd); check("R1 ctrl", {32'd0, rd}, 64'd0);
    bus_read(1'b0, 5'h08, rd); check("R1 period", {32'd0, rd}, 64'd0);
    check_dl("R1 deadline", 64'd0);
    check_out("R1", 1'b0, 1'b0);

    // sweep of base count x period through both stages
    for (int b = 0; b < 4; b++) begin
      for (int p = 0; p < 4; p++) begin
        bus_write(1'b0, 5'h00, 32'd0);
        cnt = bases[b];
        bus_write(1'b0, 5'h08, pers[p]);
        exp_dl = bases[b] + {32'd0, pers[p]};
        bus_read(1'b0, 5'h08, rd); check("R2 period rb", {32'd0, rd}, {32'd0, pers[p]});
        check_dl("R2 deadline", exp_dl);
        bus_write(1'b0, 5'h00, 32'd1);
        check_dl("R7 enable reload", exp_dl);
        bus_read(1'b0, 5'h00, rd); check("R8 enabled idle", {32'd0, rd}, 64'd1);
        run_to_expiry("R4", 1'b0, 1'b0);
        check_out("R4 first expiry", 1'b1, 1'b0);
        exp_dl = cnt + {32'd0, pers[p]};
        check_dl("R4 reload", exp_dl);
        run_to_expiry("R5", 1'b1, 1'b0);
        check_out("R5 second expiry", 1'b1, 1'b1);
        check_dl("R5 deadline kept", exp_dl);
        cnt = cnt + 64'd3;
        step();
        check_out("R5 sticky", 1'b1, 1'b1);
        check_dl("R5 no reload", exp_dl);
        bus_read(1'b0, 5'h00, rd); check("R8 full status", {32'd0, rd}, 64'd7);
        bus_write(1'b1, 5'h00, 32'hA5A5_0000 ^ pers[p]);
        exp_dl = cnt + {32'd0, pers[p]};
        check_out("R6 service clears", 1'b0, 1'b0);
        check_dl("R6 service reload", exp_dl);
      end
    end

    // R7 disabled: no expiry, no reload; re-enable reload rules
    bus_write(1'b0, 5'h00, 32'd0);
    cnt = 64'd50;
    bus_write(1'b0, 5'h08, 32'd20);
    cnt = 64'd500;
    repeat (3) step();
    check_out("R7 disabled quiet", 1'b0, 1'b0);
    check_dl("R7 no reload when off", 64'd70);
    bus_write(1'b0, 5'h00, 32'd1);
    check_dl("R7 rise reload", 64'd520);
    cnt = 64'd510;
    bus_write(1'b0, 5'h00, 32'd1);
    check_dl("R7 no reload when on", 64'd520);

    // R9 expiry colliding with a period write
    cnt = 64'd600;
    bus_write(1'b0, 5'h08, 32'd40);
    check_out("R9 write wins", 1'b0, 1'b0);
    check_dl("R9 deadline", 64'd640);

    // R6 service region at other address ignored
    bus_write(1'b1, 5'h08, 32'd123);
    bus_read(1'b0, 5'h08, rd); check("R6 ignored period", {32'd0, rd}, 64'd40);
    check_dl("R6 ignored deadline", 64'd640);

    // R8 status bits not writable, upper bits zero
    bus_write(1'b0, 5'h00, 32'hFFFF_FFFF);
    bus_read(1'b0, 5'h00, rd); check("R8 ones write", {32'd0, rd}, 64'd1);
    bus_write(1'b0, 5'h00, 32'h6);
    bus_read(1'b0, 5'h00, rd); check("R8 status write", {32'd0, rd}, 64'd0);

    // R10 unmapped and service-region reads
    bus_read(1'b0, 5'h04, rd); check("R10 0x04", {32'd0, rd}, 64'd0);
    bus_read(1'b0, 5'h0C, rd); check("R10 0x0C", {32'd0, rd}, 64'd0);
    bus_read(1'b0, 5'h18, rd); check("R10 0x18", {32'd0, rd}, 64'd0);
    bus_read(1'b0, 5'h1C, rd); check("R10 0x1C", {32'd0, rd}, 64'd0);
    bus_read(1'b1, 5'h00, rd); check("R10 service", {32'd0, rd}, 64'd0);
    bus_read(1'b1, 5'h10, rd); check("R10 service dl", {32'd0, rd}, 64'd0);

    // R3 halves independently, then a long first deadline
    bus_write(1'b0, 5'h10, 32'h1234_5678);
    bus_write(1'b0, 5'h14, 32'h9ABC_DEF0);
    check_dl("R3 halves", 64'h9ABC_DEF0_1234_5678);
    bus_read(1'b0, 5'h08, rd); check("R3 period untouched", {32'd0, rd}, 64'd40);
    bus_write(1'b0, 5'h08, 32'd10);
    cnt = 64'd100;
    bus_write(1'b0, 5'h00, 32'd1);
    bus_write(1'b0, 5'h14, 32'd1);
    bus_write(1'b0, 5'h10, 32'd0);
    check_dl("R3 long deadline", 64'h0000_0001_0000_0000);
    cnt = 64'h0000_0000_FFFF_FFFF;
    step();
    check_out("R3 before long", 1'b0, 1'b0);
    cnt = 64'h0000_0001_0000_0000;
    step();
    check_out("R3 long expiry", 1'b1, 1'b0);
    check_dl("R3 reload after long", 64'h0000_0001_0000_000A);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule